// File: doc/BRIEF.md
# DRAM Controller Event Counter Unit

This block counts activity in a DRAM controller. Eight programmable counters each watch a subset of a per-cycle event strobe vector, chosen by a bitmap in their configuration word. Two fixed counters, one for read data beats and one for write data beats, run on their own. A 64-bit register port with single-cycle requests gives access to configuration, control and counter values.

Host logic writes a configuration word for each programmable counter: an event bitmap plus an enable bit. A start command zeroes all programmable counters and opens the counting window. An end command closes it. The fixed counters are controlled only through their own enable register and write-one clear register. Programmable counters stick at their maximum value. Fixed counters roll over to zero.

Top module: `dram_perf_monitor`

## Requirements
- R1: After reset every counter, configuration word, enable and mode bit is zero and counting is inactive. Every register reads 0 and `rsp_valid_o` is low.
- R2: A read request (`req_valid_i`=1, `req_write_i`=0) gives `rsp_valid_o`=1 on the next clock edge. `rsp_rdata_o` holds the register value from before that edge. Writes give no response. Reads of unmapped or non-8-byte-aligned offsets return 0, and writes to them change nothing.
- R3: The configuration word of programmable counter n sits at byte offset 0x8040+8n and reads back exactly as written. Bit 63 is the counter enable. Bit k-1 (k = 1..55) selects event id k, which is `event_i` bit k-1.
- R4: While counting is active, a programmable counter adds exactly 1 on each clock edge where its enable is set and at least one selected event bit is high. Several selected events in the same cycle still add 1. Its value reads at 0x8080+8n.
- R5: A 4-bit selection mask 0xF placed at bit 26, 30 or 34 makes the counter count a cycle when any one of the four event bits in that group is high, and ignore event bits outside the group.
- R6: Writing 1 in bit 0 of offset 0x8028 zeroes all programmable counters on that edge and starts counting. Events in that same cycle are not counted. This register reads back the active state in bit 1. Writing 1 in bit 0 of offset 0x8030 stops counting, and the counters then hold their values.
- R7: A programmable counter at its all-ones value (CNT_W bits, default 48) stays there and does not wrap.
- R8: Offset 0x80C0 bit 0 enables the write counter, which counts cycles with `wr_beat_i` high. Bit 1 enables the read counter, which counts cycles with `rd_beat_i` high. Both counters run independent of start and end. Their values read at 0x80D0 (write) and 0x80D8 (read).
- R9: Writing 1 to bit 0 (write counter) or bit 1 (read counter) of offset 0x80C8 zeroes that fixed counter, even if a beat arrives in the same cycle. The other fixed counter is not affected. The clear register always reads 0.
- R10: A fixed counter at all-ones wraps to 0 on its next counted beat.
- R11: Bit 0 of offset 0x8020 stores the manual-mode selection and reads back as written.
- R12: Counter value offsets are read-only, and writes to them do not change the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Byte offset |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 64 | Read data |
| event_i | input | EVT_W (55) | Event strobes, bit k-1 = event id k |
| rd_beat_i | input | 1 | Read beat strobe for the fixed read counter |
| wr_beat_i | input | 1 | Write beat strobe for the fixed write counter |

## Verification
Every register effect, counter increment and clear lands on the clock edge where its request or event is sampled. A read response arrives one edge later and shows the state from before its own edge. The bench therefore drives inputs on the falling edge and predicts each response from its model state as it stood before that edge. It updates the model only after the edge and compares `rsp_valid_o`/`rsp_rdata_o` at the next falling edge. The bench narrows the counter width so that saturation and rollover can be reached within a short run.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned IDX_W  = 3;   // counter index field width, up to 8 counters

  localparam logic [ADDR_W-1:0] OFS_MODE  = 16'h8020;
  localparam logic [ADDR_W-1:0] OFS_START = 16'h8028;
  localparam logic [ADDR_W-1:0] OFS_END   = 16'h8030;
  localparam logic [ADDR_W-1:0] OFS_CFG0  = 16'h8040;
  localparam logic [ADDR_W-1:0] OFS_VAL0  = 16'h8080;
  localparam logic [ADDR_W-1:0] OFS_FEN   = 16'h80C0;
  localparam logic [ADDR_W-1:0] OFS_FCLR  = 16'h80C8;
  localparam logic [ADDR_W-1:0] OFS_FWR   = 16'h80D0;
  localparam logic [ADDR_W-1:0] OFS_FRD   = 16'h80D8;

  localparam int unsigned EN_BIT = 63;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_START, SEL_END, SEL_CFG,
    SEL_VAL, SEL_FEN, SEL_FCLR, SEL_FWR, SEL_FRD
  } reg_sel_e;
endpackage

// File: rtl/dpm_addr_dec.sv
module dpm_addr_dec
  import dpm_pkg::*;
#(
  parameter int unsigned NUM_PROG = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic idx_ok;
  assign idx_o  = addr_i[5:3];
  assign idx_ok = {29'd0, addr_i[5:3]} < NUM_PROG;

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[2:0] == 3'b000) begin
      if (addr_i[ADDR_W-1:6] == OFS_CFG0[ADDR_W-1:6]) begin
        sel_o = idx_ok ? SEL_CFG : SEL_NONE;
      end else if (addr_i[ADDR_W-1:6] == OFS_VAL0[ADDR_W-1:6]) begin
        sel_o = idx_ok ? SEL_VAL : SEL_NONE;
      end else begin
        case (addr_i)
          OFS_MODE:  sel_o = SEL_MODE;
          OFS_START: sel_o = SEL_START;
          OFS_END:   sel_o = SEL_END;
          OFS_FEN:   sel_o = SEL_FEN;
          OFS_FCLR:  sel_o = SEL_FCLR;
          OFS_FWR:   sel_o = SEL_FWR;
          OFS_FRD:   sel_o = SEL_FRD;
          default:   sel_o = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpm_prog_cnt.sv
module dpm_prog_cnt #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned EVT_W = 55
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             active_i,
  input  logic             en_i,
  input  logic [EVT_W-1:0] mask_i,
  input  logic [EVT_W-1:0] evt_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic hit;
  assign hit = en_i & active_i & (|(mask_i & evt_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= '0;
    else if (hit && (cnt_o != CNT_MAX)) cnt_o <= cnt_o + 1'b1;
  end

  a_r6_start_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  a_r7_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
  a_r4_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !active_i) |=> $stable(cnt_o));
endmodule

// File: rtl/dpm_fixed_cnt.sv
module dpm_fixed_cnt #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             beat_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (clr_i)         cnt_o <= '0;
    else if (en_i && beat_i) cnt_o <= cnt_o + 1'b1;  // rolls over
  end

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  a_r10_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && beat_i && cnt_o == CNT_MAX) |=> (cnt_o == '0));
  a_r8_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(en_i && beat_i)) |=> $stable(cnt_o));
endmodule

// File: rtl/dram_perf_monitor.sv
module dram_perf_monitor
  import dpm_pkg::*;
#(
  parameter int unsigned NUM_PROG = 8,
  parameter int unsigned CNT_W    = 48,
  parameter int unsigned EVT_W    = 55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [63:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  input  logic [EVT_W-1:0]  event_i,
  input  logic              rd_beat_i,
  input  logic              wr_beat_i
);
  reg_sel_e             sel;
  logic [IDX_W-1:0]     idx;
  logic                 wr_en, rd_en;
  logic                 start_p, end_p, fclr_wr, fclr_rd;
  logic                 mode_q, active_q;
  logic [1:0]           fen_q;               // [0] write counter, [1] read counter
  logic [63:0]          cfg_q [NUM_PROG];
  logic [CNT_W-1:0]     prog_val [NUM_PROG];
  logic [CNT_W-1:0]     fwr_val, frd_val;
  logic [63:0]          rdata_d;

  dpm_addr_dec #(.NUM_PROG(NUM_PROG)) i_dec (
    .addr_i (req_addr_i),
    .sel_o  (sel),
    .idx_o  (idx)
  );

  assign wr_en   = req_valid_i & req_write_i;
  assign rd_en   = req_valid_i & ~req_write_i;
  assign start_p = wr_en && sel == SEL_START && req_wdata_i[0];
  assign end_p   = wr_en && sel == SEL_END   && req_wdata_i[0];
  assign fclr_wr = wr_en && sel == SEL_FCLR  && req_wdata_i[0];
  assign fclr_rd = wr_en && sel == SEL_FCLR  && req_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      active_q <= 1'b0;
      fen_q    <= 2'b00;
    end else begin
      if (wr_en && sel == SEL_MODE) mode_q <= req_wdata_i[0];
      if (wr_en && sel == SEL_FEN)  fen_q  <= req_wdata_i[1:0];
      if (start_p)                  active_q <= 1'b1;
      else if (end_p)               active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NUM_PROG; n++) cfg_q[n] <= '0;
    end else if (wr_en && sel == SEL_CFG) begin
      cfg_q[idx] <= req_wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog
    dpm_prog_cnt #(.CNT_W(CNT_W), .EVT_W(EVT_W)) i_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (start_p),
      .active_i (active_q),
      .en_i     (cfg_q[g][EN_BIT]),
      .mask_i   (cfg_q[g][EVT_W-1:0]),
      .evt_i    (event_i),
      .cnt_o    (prog_val[g])
    );
  end

  dpm_fixed_cnt #(.CNT_W(CNT_W)) i_fix_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fclr_wr),
    .en_i   (fen_q[0]),
    .beat_i (wr_beat_i),
    .cnt_o  (fwr_val)
  );

  dpm_fixed_cnt #(.CNT_W(CNT_W)) i_fix_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fclr_rd),
    .en_i   (fen_q[1]),
    .beat_i (rd_beat_i),
    .cnt_o  (frd_val)
  );

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_MODE:  rdata_d[0]   = mode_q;
      SEL_START: rdata_d[1]   = active_q;
      SEL_CFG:   rdata_d      = cfg_q[idx];
      SEL_VAL:   rdata_d      = 64'(prog_val[idx]);
      SEL_FEN:   rdata_d[1:0] = fen_q;
      SEL_FWR:   rdata_d      = 64'(fwr_val);
      SEL_FRD:   rdata_d      = 64'(frd_val);
      default:   rdata_d      = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_en;
      rsp_rdata_o <= rd_en ? rdata_d : '0;
    end
  end

  a_r2_rsp_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> rsp_valid_o);
  a_r2_no_rsp_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en) |=> !rsp_valid_o);
  a_r6_start_sets_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p |=> active_q);
  a_r6_end_clears_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_p |=> !active_q);
endmodule

// File: tb/test_dram_perf_monitor.sv
module test_dram_perf_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int TB_W  = 6;
  localparam int EVT_W = 55;
  localparam logic [TB_W-1:0] MAXV = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rv = 1'b0, rw = 1'b0;
  logic [15:0]       ra = '0;
  logic [63:0]       rwd = '0;
  logic [EVT_W-1:0]  evt = '0;
  logic              rb = 1'b0, wb = 1'b0;
  logic              rsp_v;
  logic [63:0]       rsp_d;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_perf_monitor #(.CNT_W(TB_W), .EVT_W(EVT_W)) i_dram_perf_monitor (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv), .req_write_i(rw),
    .req_addr_i(ra), .req_wdata_i(rwd), .rsp_valid_o(rsp_v), .rsp_rdata_o(rsp_d),
    .event_i(evt), .rd_beat_i(rb), .wr_beat_i(wb)
  );

  // reference model
  logic [63:0]     m_cfg [8];
  logic [TB_W-1:0] m_cnt [8];
  logic            m_act, m_mode;
  logic [1:0]      m_fen;
  logic [TB_W-1:0] m_fw, m_fr;

  function automatic logic [63:0] m_read(input logic [15:0] a);
    if (a[2:0] != 3'b0) return 64'd0;
    if (a[15:6] == 10'h201) return m_cfg[a[5:3]];
    if (a[15:6] == 10'h202) return 64'(m_cnt[a[5:3]]);
    case (a)
      16'h8020: return {63'd0, m_mode};
      16'h8028: return {62'd0, m_act, 1'b0};
      16'h80C0: return {62'd0, m_fen};
      16'h80D0: return 64'(m_fw);
      16'h80D8: return 64'(m_fr);
      default:  return 64'd0;
    endcase
  endfunction

  task automatic model_step(input logic v, input logic w, input logic [15:0] a, input logic [63:0] d);
    logic wr_ok, st, en;
    wr_ok = v && w && (a[2:0] == 3'b0);
    st = wr_ok && a == 16'h8028 && d[0];
    en = wr_ok && a == 16'h8030 && d[0];
    for (int n = 0; n < 8; n++) begin
      if (st) m_cnt[n] = '0;
      else if (m_act && m_cfg[n][63] && (|(m_cfg[n][EVT_W-1:0] & evt)) && m_cnt[n] != MAXV)
        m_cnt[n] = m_cnt[n] + 1'b1;
    end
    if (wr_ok && a == 16'h80C8 && d[0]) m_fw = '0;
    else if (m_fen[0] && wb) m_fw = m_fw + 1'b1;
    if (wr_ok && a == 16'h80C8 && d[1]) m_fr = '0;
    else if (m_fen[1] && rb) m_fr = m_fr + 1'b1;
    if (st) m_act = 1'b1;
    else if (en) m_act = 1'b0;
    if (wr_ok && a == 16'h8020) m_mode = d[0];
    if (wr_ok && a == 16'h80C0) m_fen = d[1:0];
    if (wr_ok && a[15:6] == 10'h201) m_cfg[a[5:3]] = d;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one request cycle; starts and ends at a falling edge
  task automatic tick(input logic v, input logic w, input logic [15:0] a,
                      input logic [63:0] d, input string tag, output logic [63:0] got);
    logic [63:0] exp;
    exp = m_read(a);
    rv = v; rw = w; ra = a; rwd = d;
    @(posedge clk);
    model_step(v, w, a, d);
    @(negedge clk);
    rv = 1'b0; rw = 1'b0;
    check({tag, " rsp_valid"}, 64'(rsp_v), 64'(v && !w));
    if (v && !w) check(tag, rsp_d, exp);
    got = rsp_d;
  endtask

  task automatic idle(input int n);
    logic [63:0] g;
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 16'h0, 64'h0, "idle", g);
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    logic [63:0] g;
    tick(1'b1, 1'b1, a, d, "write", g);
  endtask

  task automatic rd_lit(input logic [15:0] a, input logic [63:0] lit, input string tag);
    logic [63:0] g;
    tick(1'b1, 1'b0, a, 64'h0, tag, g);
    check({tag, " literal"}, g, lit);
  endtask

  function automatic logic [15:0] pick_addr(input int unsigned r);
    case (r % 12)
      0: return 16'h8020;  1: return 16'h8028;  2: return 16'h8030;
      3: return 16'h8040 + 16'(($urandom % 8) * 8);
      4: return 16'h8080 + 16'(($urandom % 8) * 8);
      5: return 16'h80C0;  6: return 16'h80C8;  7: return 16'h80D0;
      8: return 16'h80D8;  9: return 16'h8038;
      10: return 16'($urandom);
      default: return 16'h8044;
    endcase
  endfunction

  function automatic logic [EVT_W-1:0] sparse();
    logic [63:0] a, b;
    a = {$urandom, $urandom};
    b = {$urandom, $urandom};
    return EVT_W'(a & b & {$urandom, $urandom});
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] g;
    logic [63:0] c0;
    void'($urandom(32'd20240917));
    for (int n = 0; n < 8; n++) begin m_cfg[n] = '0; m_cnt[n] = '0; end
    m_act = 0; m_mode = 0; m_fen = 0; m_fw = 0; m_fr = 0;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", 64'(rsp_v), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_lit(16'h8080, 0, "R1 val0");
    rd_lit(16'h80D8, 0, "R1 fixed rd");
    rd_lit(16'h8040, 0, "R1 cfg0");
    rd_lit(16'h8028, 0, "R1 active");
    rd_lit(16'h80C0, 0, "R1 fen");

    // R11 mode bit
    wr(16'h8020, 64'd1);
    rd_lit(16'h8020, 1, "R11 mode");

    // R3 configuration words
    c0 = (64'd1 << 63) | 64'd1;
    wr(16'h8040, c0);
    rd_lit(16'h8040, c0, "R3 cfg0 readback");
    wr(16'h8048, (64'd1 << 63) | (64'd1 << 4) | (64'd1 << 10));
    wr(16'h8050, (64'd1 << 63) | (64'hF << 26));
    wr(16'h8058, 64'hF << 30);
    wr(16'h8060, (64'd1 << 63) | (64'd1 << 54));

    // R2 unmapped / unaligned
    rd_lit(16'h8038, 0, "R2 unmapped");
    rd_lit(16'h8044, 0, "R2 unaligned");
    wr(16'h9040, '1);
    wr(16'h8041, '1);
    rd_lit(16'h8040, c0, "R2 ignored write");

    // R6 start, events in start cycle dropped
    evt = EVT_W'(1);
    wr(16'h8028, 64'd1);
    idle(4);
    evt = '0;
    rd_lit(16'h8080, 4, "R6 start then count");
    rd_lit(16'h8028, 2, "R6 active readback");

    // R4 coincident events add one
    evt = (EVT_W'(1) << 4) | (EVT_W'(1) << 10);
    idle(3);
    evt = '0;
    rd_lit(16'h8088, 3, "R4 one per cycle");

    // R5 power-state group
    evt = EVT_W'(1) << 28; idle(2);
    evt = (EVT_W'(1) << 29) | (EVT_W'(1) << 26); idle(1);
    evt = EVT_W'(1) << 30; idle(2);
    evt = '0;
    rd_lit(16'h8090, 3, "R5 group count");
    rd_lit(16'h8098, 0, "R3 disabled counter");

    // R3 highest event id
    evt = EVT_W'(1) << 54; idle(2); evt = '0;
    rd_lit(16'h80A0, 2, "R3 id55");

    // R6 end holds values
    wr(16'h8030, 64'd1);
    evt = EVT_W'(1); idle(3); evt = '0;
    rd_lit(16'h8080, 4, "R6 end holds");
    rd_lit(16'h8028, 0, "R6 inactive");

    // R6 restart clears
    evt = EVT_W'(1);
    wr(16'h8028, 64'd1);
    evt = '0;
    rd_lit(16'h8080, 0, "R6 restart clears");

    // R7 saturation
    evt = EVT_W'(1); idle(70);
    rd_lit(16'h8080, 64'(MAXV), "R7 saturate");
    idle(2);
    rd_lit(16'h8080, 64'(MAXV), "R7 hold at max");
    evt = '0;

    // R12 value registers read-only
    wr(16'h8080, 64'd5);
    rd_lit(16'h8080, 64'(MAXV), "R12 read-only");

    // R8 fixed counters
    wb = 1; rb = 1;
    wr(16'h80C0, 64'd1);
    idle(5);
    wb = 0; rb = 0;
    rd_lit(16'h80D0, 5, "R8 write counter");
    rd_lit(16'h80D8, 0, "R8 read counter disabled");
    wr(16'h8030, 64'd1);
    wb = 1; idle(3); wb = 0;
    rd_lit(16'h80D0, 8, "R8 independent of end");

    // R9 clear wins over beat
    wb = 1;
    wr(16'h80C8, 64'd1);
    wb = 0;
    rd_lit(16'h80D0, 0, "R9 clear");
    rd_lit(16'h80C8, 0, "R9 clear reads zero");

    // R10 wrap
    wb = 1; idle(64); idle(3); wb = 0;
    rd_lit(16'h80D0, 3, "R10 wrap");

    // R9 read clear leaves write counter alone
    wr(16'h80C0, 64'd3);
    rb = 1; idle(4);
    wr(16'h80C8, 64'd2);
    rb = 0;
    rd_lit(16'h80D8, 0, "R9 read clear");
    rd_lit(16'h80D0, 3, "R9 other counter kept");

    // constrained random phase, checked against the model (R4)
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      logic [15:0] a;
      logic [63:0] d;
      evt = sparse();
      rb = 1'($urandom); wb = 1'($urandom);
      op = $urandom % 10;
      a = pick_addr($urandom);
      d = {$urandom, $urandom};
      if (op < 5) tick(1'b0, 1'b0, 16'h0, 64'h0, "R4 rand idle", g);
      else if (op < 8) tick(1'b1, 1'b0, a, 64'h0, "R4 rand read", g);
      else if (op == 8) begin
        if (a[15:6] == 10'h201) d = {d[63], 8'd0, d[54:0] & {$urandom, $urandom}};
        tick(1'b1, 1'b1, a, d, "R4 rand write", g);
      end else tick(1'b1, 1'b1, ($urandom % 2) ? 16'h8028 : 16'h8030, 64'd1, "R6 rand ctl", g);
    end
    evt = '0;
    for (int n = 0; n < 8; n++) begin
      tick(1'b1, 1'b0, 16'h8080 + 16'(n * 8), 64'h0, "R4 final value", g);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule